// File: doc/BRIEF.md
# Table-Driven Multi-Pattern DFA Matcher

This block scans packet payloads one byte at a time through a deterministic automaton. The automaton recognises many patterns at once and is held in an on-block transition memory. The memory has one row per automaton state and one column per byte value, so it has 256 columns. Each 32-bit transition word packs two things. The upper half is the state to move to. The lower half is a pattern identifier, where zero means the destination is not an accepting state.

For every byte, the matcher forms the memory address from its current state and the byte. One cycle later it receives the word for that address. Because the next address is taken straight from the word that was just read, the matcher accepts a new byte on every clock cycle.

A word with a nonzero identifier produces a report. The report holds that identifier and the index of the payload byte that completed the pattern. It is written into the result row that belongs to the current packet. Rows are used in packet order and wrap around after the last one. Slot 0 of each row counts the reports and slot k holds the k-th report. Each accepted report rewrites the count slot with the new total. When a row is full, later reports are dropped and the packet is marked as overflowed. At the last byte of each packet, the block gives a one-cycle summary of the final count and the overflow flag.

Top module: `dfa_matcher`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, `rpt_we`, `cnt_we` and `done_valid` are 0. The first packet after reset uses row 0.
- R2: The transition address is {current state, byte}. The next state is bits 31:16 of the word read, and only its low `STATE_W` bits are used.
- R3: A byte whose transition word has bits 15:0 equal to zero produces no report and no count write, unless that byte starts a packet.
- R4: A byte whose word has a nonzero ID (bits 15:0) produces a report. `rpt_id` is that ID and `rpt_idx` is the byte's 0-based index in its packet. The report appears two clock edges after the edge that accepted the byte.
- R5: Report number k of a packet is written to slot k, and k runs from 1. In the same cycle, `cnt_we` writes k to slot 0 of the same row.
- R6: A byte with `in_sop` high starts from state 0 and index 0, and it resets the count to 0. If that byte does not match, a count write with value 0 clears the row's count slot.
- R7: The matcher accepts a byte on every cycle that `in_valid` is high. Idle cycles between bytes leave the state and the index unchanged.
- R8: A row holds at most ROW_SLOTS-1 reports. Any further match in the same packet is dropped with no report and no count write, and the packet's overflow flag is set.
- R9: The byte with `in_eop` high produces a `done_valid` pulse carrying the packet's final count and overflow flag. The row number then advances and wraps from NUM_ROWS-1 back to 0.
- R10: `tbl_we` writes `tbl_word` at {`tbl_state`, `tbl_byte`}. Bytes scanned afterwards use the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Transition memory write enable |
| tbl_state | input | STATE_W | State (row) of the word being written |
| tbl_byte | input | 8 | Byte value (column) of the word being written |
| tbl_word | input | 32 | Next state in bits 31:16, pattern ID in bits 15:0 |
| in_valid | input | 1 | Payload byte present |
| in_byte | input | 8 | Payload byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| rpt_we | output | 1 | Report write strobe |
| rpt_row | output | ROW_W | Result row of the report |
| rpt_slot | output | SLOT_W | Slot of the report, from 1 upward |
| rpt_id | output | 16 | Pattern ID |
| rpt_idx | output | 16 | Index of the byte that completed the pattern |
| cnt_we | output | 1 | Count slot write strobe |
| cnt_row | output | ROW_W | Row whose slot 0 is written |
| cnt_value | output | SLOT_W | New count value |
| done_valid | output | 1 | End-of-packet summary strobe |
| done_count | output | SLOT_W | Final report count of the packet |
| done_ovf | output | 1 | Reports were dropped in the packet |

## Verification
The test automaton matches a three-byte chain that completes two patterns one byte apart. It also matches a one-byte pattern from any state.

Several kinds of payload are scanned:
- A packet with back-to-back bytes, and another with idle gaps, show whether the state carries correctly across pipelined and stalled reads.
- A packet that ends halfway through a chain, followed by a packet that continues the chain, shows whether the start of a packet really resets the state.
- A run of ten one-byte matches overflows the row.
- A single-byte packet checks the case where the start and end of a packet fall on the same byte.

Enough packets are sent to wrap the row number. The last test rewrites one table word between packets and checks that the new word takes effect.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
    localparam int WORD_W = 32;
    localparam int ID_W   = 16;
    localparam int IDX_W  = 16;
    localparam int BYTE_W = 8;

    // One accepted byte as it leaves the address stage.
    typedef struct packed {
        logic             valid;
        logic             sop;
        logic             eop;
        logic [IDX_W-1:0] idx;
    } scan_beat_t;

    function automatic logic [ID_W-1:0] word_id(input logic [WORD_W-1:0] w);
        return w[ID_W-1:0];
    endfunction

    function automatic logic [WORD_W-ID_W-1:0] word_next(input logic [WORD_W-1:0] w);
        return w[WORD_W-1:ID_W];
    endfunction
endpackage

// File: rtl/dfa_table_mem.sv
module dfa_table_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // The read register holds its word until the next read, so it also carries the state across idle cycles.
    always_comb begin
        rd_d = rd_q;
        if (rd_en) rd_d = mem[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/dfa_scan_stage.sv
module dfa_scan_stage
    import dfa_pkg::*;
#(
    parameter int STATE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [BYTE_W-1:0]        in_byte,
    input  logic                     in_sop,
    input  logic                     in_eop,
    input  logic [STATE_W-1:0]       held_state,
    output logic                     rd_en,
    output logic [STATE_W+BYTE_W-1:0] rd_addr,
    output scan_beat_t               beat
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        scan_beat_t       beat;
    } scan_regs_t;

    scan_regs_t r_d, r_q;
    logic [STATE_W-1:0] cur_state;
    logic [IDX_W-1:0]   cur_idx;

    always_comb begin
        r_d       = r_q;
        cur_state = in_sop ? '0 : held_state;
        cur_idx   = in_sop ? '0 : r_q.idx;
        rd_en     = in_valid;
        rd_addr   = {cur_state, in_byte};
        r_d.beat  = '0;
        if (in_valid) begin
            r_d.idx        = cur_idx + 1'b1;
            r_d.beat.valid = 1'b1;
            r_d.beat.sop   = in_sop;
            r_d.beat.eop   = in_eop;
            r_d.beat.idx   = cur_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign beat = r_q.beat;
endmodule

// File: rtl/dfa_report_writer.sv
module dfa_report_writer
    import dfa_pkg::*;
#(
    parameter int NUM_ROWS  = 4,
    parameter int ROW_SLOTS = 8,
    localparam int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    localparam int SLOT_W   = $clog2(ROW_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  scan_beat_t        beat,
    input  logic [ID_W-1:0]   hit_id,
    output logic              rpt_we,
    output logic [ROW_W-1:0]  rpt_row,
    output logic [SLOT_W-1:0] rpt_slot,
    output logic [ID_W-1:0]   rpt_id,
    output logic [IDX_W-1:0]  rpt_idx,
    output logic              cnt_we,
    output logic [ROW_W-1:0]  cnt_row,
    output logic [SLOT_W-1:0] cnt_value,
    output logic              done_valid,
    output logic [SLOT_W-1:0] done_count,
    output logic              done_ovf
);
    localparam logic [SLOT_W-1:0] MAX_RPT  = SLOT_W'(ROW_SLOTS - 1);
    localparam logic [ROW_W-1:0]  LAST_ROW = ROW_W'(NUM_ROWS - 1);

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [SLOT_W-1:0] cnt;
        logic              ovf;
        logic              rpt_we;
        logic [ROW_W-1:0]  rpt_row;
        logic [SLOT_W-1:0] rpt_slot;
        logic [ID_W-1:0]   rpt_id;
        logic [IDX_W-1:0]  rpt_idx;
        logic              cnt_we;
        logic [ROW_W-1:0]  cnt_row;
        logic [SLOT_W-1:0] cnt_value;
        logic              done_valid;
        logic [SLOT_W-1:0] done_count;
        logic              done_ovf;
    } wr_regs_t;

    wr_regs_t w_d, w_q;
    logic [SLOT_W-1:0] base_cnt, new_cnt;
    logic              base_ovf, new_ovf, hit, room;

    always_comb begin
        w_d          = w_q;
        w_d.rpt_we   = 1'b0;
        w_d.cnt_we   = 1'b0;
        w_d.done_valid = 1'b0;
        base_cnt = beat.sop ? '0 : w_q.cnt;
        base_ovf = beat.sop ? 1'b0 : w_q.ovf;
        hit      = beat.valid && (hit_id != '0);
        room     = base_cnt < MAX_RPT;
        new_cnt  = base_cnt;
        new_ovf  = base_ovf;
        if (hit) begin
            if (room) new_cnt = base_cnt + 1'b1;
            else      new_ovf = 1'b1;
        end
        if (beat.valid) begin
            w_d.cnt = new_cnt;
            w_d.ovf = new_ovf;
            if (hit && room) begin
                w_d.rpt_we   = 1'b1;
                w_d.rpt_row  = w_q.row;
                w_d.rpt_slot = new_cnt;
                w_d.rpt_id   = hit_id;
                w_d.rpt_idx  = beat.idx;
            end
            if ((hit && room) || beat.sop) begin
                w_d.cnt_we    = 1'b1;
                w_d.cnt_row   = w_q.row;
                w_d.cnt_value = new_cnt;
            end
            if (beat.eop) begin
                w_d.done_valid = 1'b1;
                w_d.done_count = new_cnt;
                w_d.done_ovf   = new_ovf;
                w_d.row        = (w_q.row == LAST_ROW) ? '0 : w_q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign rpt_we     = w_q.rpt_we;
    assign rpt_row    = w_q.rpt_row;
    assign rpt_slot   = w_q.rpt_slot;
    assign rpt_id     = w_q.rpt_id;
    assign rpt_idx    = w_q.rpt_idx;
    assign cnt_we     = w_q.cnt_we;
    assign cnt_row    = w_q.cnt_row;
    assign cnt_value  = w_q.cnt_value;
    assign done_valid = w_q.done_valid;
    assign done_count = w_q.done_count;
    assign done_ovf   = w_q.done_ovf;
endmodule

// File: rtl/dfa_matcher.sv
module dfa_matcher
    import dfa_pkg::*;
#(
    parameter int STATE_W   = 3,
    parameter int NUM_ROWS  = 4,
    parameter int ROW_SLOTS = 8,
    localparam int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    localparam int SLOT_W   = $clog2(ROW_SLOTS),
    localparam int ADDR_W   = STATE_W + BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_we,
    input  logic [STATE_W-1:0] tbl_state,
    input  logic [7:0]         tbl_byte,
    input  logic [31:0]        tbl_word,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    input  logic               in_sop,
    input  logic               in_eop,
    output logic               rpt_we,
    output logic [ROW_W-1:0]   rpt_row,
    output logic [SLOT_W-1:0]  rpt_slot,
    output logic [15:0]        rpt_id,
    output logic [15:0]        rpt_idx,
    output logic               cnt_we,
    output logic [ROW_W-1:0]   cnt_row,
    output logic [SLOT_W-1:0]  cnt_value,
    output logic               done_valid,
    output logic [SLOT_W-1:0]  done_count,
    output logic               done_ovf
);
    logic                 rd_en;
    logic [ADDR_W-1:0]    rd_addr;
    logic [WORD_W-1:0]    word;
    logic [WORD_W-ID_W-1:0] next_full;
    scan_beat_t           beat;

    assign next_full = word_next(word);

    dfa_table_mem #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_addr({tbl_state, tbl_byte}), .wr_data(tbl_word),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(word)
    );

    dfa_scan_stage #(.STATE_W(STATE_W)) u_scan (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_byte(in_byte), .in_sop(in_sop), .in_eop(in_eop),
        .held_state(next_full[STATE_W-1:0]),
        .rd_en(rd_en), .rd_addr(rd_addr), .beat(beat)
    );

    dfa_report_writer #(.NUM_ROWS(NUM_ROWS), .ROW_SLOTS(ROW_SLOTS)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .beat(beat), .hit_id(word_id(word)),
        .rpt_we(rpt_we), .rpt_row(rpt_row), .rpt_slot(rpt_slot),
        .rpt_id(rpt_id), .rpt_idx(rpt_idx),
        .cnt_we(cnt_we), .cnt_row(cnt_row), .cnt_value(cnt_value),
        .done_valid(done_valid), .done_count(done_count), .done_ovf(done_ovf)
    );
endmodule

// File: rtl/dfa_matcher_chk.sv
module dfa_matcher_chk #(
    parameter int ROW_W  = 2,
    parameter int SLOT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              rpt_we,
    input logic [ROW_W-1:0]  rpt_row,
    input logic [SLOT_W-1:0] rpt_slot,
    input logic [15:0]       rpt_id,
    input logic              cnt_we,
    input logic [ROW_W-1:0]  cnt_row,
    input logic [SLOT_W-1:0] cnt_value,
    input logic              done_valid,
    input logic [SLOT_W-1:0] done_count,
    input logic              done_ovf
);
    localparam logic [SLOT_W-1:0] MAXR = {SLOT_W{1'b1}};

    AST_RPT_NONZERO_ID: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_we |-> rpt_id != 16'd0); // R3
    AST_RPT_SLOT_PAIRS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_we |-> (cnt_we && cnt_value == rpt_slot && cnt_row == rpt_row && rpt_slot != '0)); // R5
    AST_OVF_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_ovf) |-> done_count == MAXR); // R8
    AST_NO_OUTPUT_WITHOUT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid, 2) |-> (!rpt_we && !cnt_we && !done_valid)); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!rpt_we && !cnt_we && !done_valid)); // R1
endmodule

bind dfa_matcher dfa_matcher_chk #(.ROW_W(ROW_W), .SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .rpt_we(rpt_we), .rpt_row(rpt_row), .rpt_slot(rpt_slot), .rpt_id(rpt_id),
    .cnt_we(cnt_we), .cnt_row(cnt_row), .cnt_value(cnt_value),
    .done_valid(done_valid), .done_count(done_count), .done_ovf(done_ovf)
);

// File: tb/dfa_matcher_bench.sv
module dfa_matcher_bench;
    localparam int STATE_W = 3, NUM_ROWS = 4, ROW_SLOTS = 8;
    localparam int ROW_W = 2, SLOT_W = 3, MAXR = ROW_SLOTS - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tbl_we = 1'b0; logic [STATE_W-1:0] tbl_state = '0;
    logic [7:0] tbl_byte = '0; logic [31:0] tbl_word = '0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0; logic [7:0] in_byte = '0;
    logic rpt_we, cnt_we, done_valid, done_ovf;
    logic [ROW_W-1:0] rpt_row, cnt_row; logic [SLOT_W-1:0] rpt_slot, cnt_value, done_count;
    logic [15:0] rpt_id, rpt_idx;

    always #2.5 clk = ~clk;

    dfa_matcher #(.STATE_W(STATE_W), .NUM_ROWS(NUM_ROWS), .ROW_SLOTS(ROW_SLOTS)) u_dfa_matcher (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_state(tbl_state), .tbl_byte(tbl_byte),
        .tbl_word(tbl_word), .in_valid(in_valid), .in_byte(in_byte), .in_sop(in_sop),
        .in_eop(in_eop), .rpt_we(rpt_we), .rpt_row(rpt_row), .rpt_slot(rpt_slot),
        .rpt_id(rpt_id), .rpt_idx(rpt_idx), .cnt_we(cnt_we), .cnt_row(cnt_row),
        .cnt_value(cnt_value), .done_valid(done_valid), .done_count(done_count), .done_ovf(done_ovf));

    int n_cmp = 0, n_bad = 0;
    bit finished = 0, override_q = 0;
    logic [47:0] rpt_exp[$];
    logic [15:0] cnt_exp[$];
    logic [15:0] done_exp[$];
    int m_state = 0, m_idx = 0, m_cnt = 0, m_row = 0; bit m_ovf = 0;

    // Reference automaton: "ab" -> 0x21, "abc" -> 0x42, "z" -> 0x07 from any state.
    function automatic logic [31:0] ref_word(int s, int b);
        if (override_q && s == 0 && b == "q") return {16'd0, 16'h0099};
        if (b == "z") return {16'd0, 16'h0007};
        if (b == "a") return {16'd1, 16'd0};
        if (s == 1 && b == "b") return {16'd2, 16'h0021};
        if (s == 2 && b == "c") return {16'd0, 16'h0042};
        return 32'd0;
    endfunction

    task automatic check(string req, logic [47:0] act, logic [47:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: feeds one packet and pushes expected items into the scoreboard queues.
    task automatic send(string s, int gap);
        for (int i = 0; i < s.len(); i++) begin
            logic [31:0] w;
            in_valid = 1'b1; in_byte = s[i]; in_sop = (i == 0); in_eop = (i == s.len() - 1);
            if (i == 0) begin m_state = 0; m_idx = 0; m_cnt = 0; m_ovf = 0; end
            w = ref_word(m_state, s[i]);
            m_state = int'(w[31:16]);
            if (w[15:0] != 16'd0) begin
                if (m_cnt < MAXR) begin
                    m_cnt++;
                    rpt_exp.push_back({8'(m_row), 8'(m_cnt), w[15:0], 16'(m_idx)});
                    cnt_exp.push_back({8'(m_row), 8'(m_cnt)});
                end else m_ovf = 1;
            end else if (i == 0) cnt_exp.push_back({8'(m_row), 8'(0)});
            if (i == 0 && w[15:0] != 16'd0 && m_cnt == 0) cnt_exp.push_back({8'(m_row), 8'(0)});
            m_idx++;
            if (i == s.len() - 1) begin
                done_exp.push_back({8'(m_cnt), 7'd0, m_ovf});
                m_row = (m_row + 1) % NUM_ROWS;
            end
            @(negedge clk);
            if (gap > 0) begin
                in_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    // Monitor: pops and compares as the design writes results.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (rpt_we) begin
                    if (rpt_exp.size() == 0) check("R3 unexpected report", {8'(rpt_row), 8'(rpt_slot), rpt_id, rpt_idx}, 48'd0);
                    else check("R4/R5 report", {8'(rpt_row), 8'(rpt_slot), rpt_id, rpt_idx}, rpt_exp.pop_front());
                end
                if (cnt_we) begin
                    if (cnt_exp.size() == 0) check("R5/R6 unexpected count write", 48'({8'(cnt_row), 8'(cnt_value)}), 48'hFFFF);
                    else check("R5/R6 count slot", 48'({8'(cnt_row), 8'(cnt_value)}), 48'(cnt_exp.pop_front()));
                end
                if (done_valid) begin
                    if (done_exp.size() == 0) check("R9 unexpected done", 48'({8'(done_count), 7'd0, done_ovf}), 48'hFFFF);
                    else check("R8/R9 packet summary", 48'({8'(done_count), 7'd0, done_ovf}), 48'(done_exp.pop_front()));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R7 watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 outputs quiet in reset", 48'({rpt_we, cnt_we, done_valid}), 48'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs quiet after reset", 48'({rpt_we, cnt_we, done_valid}), 48'd0);
        // R10: load the full table through the write port.
        for (int s = 0; s < (1 << STATE_W); s++)
            for (int b = 0; b < 256; b++) begin
                tbl_we = 1'b1; tbl_state = STATE_W'(s); tbl_byte = 8'(b); tbl_word = ref_word(s, b);
                @(negedge clk);
            end
        tbl_we = 1'b0;
        send("xxabcx", 0);      // R2 R4: chain with two completions back to back
        send("aab", 2);         // R7: idle gaps keep state
        send("zxa", 0);         // ends mid-chain (state 1)
        send("bc", 0);          // R6: new packet restarts at state 0, no match; row wraps after this (R9)
        send("zzzzzzzzzz", 0);  // R8: overflow
        send("z", 1);           // R6 R9: sop and eop on one byte
        send("xyxy", 0);        // R3: no matches, count cleared only
        repeat (3) @(negedge clk);
        // R10: rewrite one word between packets.
        override_q = 1;
        tbl_we = 1'b1; tbl_state = '0; tbl_byte = "q"; tbl_word = ref_word(0, "q");
        @(negedge clk); tbl_we = 1'b0;
        send("qab", 0);
        repeat (10) @(negedge clk);
        check("R4 all reports seen", 48'(rpt_exp.size()), 48'd0);
        check("R5 all count writes seen", 48'(cnt_exp.size()), 48'd0);
        check("R9 all summaries seen", 48'(done_exp.size()), 48'd0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule